// File: doc/BRIEF.md
# Auto-Reload Baud Timer Generator

This block is a 16-bit up-counter that reloads itself from a 16-bit reload register each time it wraps. Its overflow pulses serve as a serial port's shift-clock source. The counter is driven either by the system clock divided by two or by falling edges on an external clock pin. Each wrap reloads the counter quietly: no overflow flag is set and no interrupt is raised.

There are two baud channels, one for receive and one for transmit. Each channel picks its source on its own, either this counter's overflow or an overflow pulse from another timer. The chosen pulses go through a fixed divide-by-16, and the channel emits a one-cycle tick at sixteen times the bit rate. With the internal timebase the tick period is 32 × (65536 − reload) system clocks. With the external pin it is 16 × (65536 − reload) pin periods.

A separate trigger pin can set a sticky flag on its falling edges. The flag, together with an enable, forms an interrupt request. This makes the trigger pin usable as an extra external interrupt source.

Top module: `baud_timer_gen`

## Requirements
- R1: After reset, rx_tick, tx_tick, ext_flag and irq are 0. The counter starts at all ones, so its first advance loads the reload value. With reload 0xFFFF written before run_en is raised, the first rx_tick appears 33 cycles after run_en goes high.
- R2: With src_ext=0 and run_en=1, the counter advances once every 2 system clocks. A channel fed by the counter ticks every 32 × (65536 − reload) cycles.
- R3: A counter wrap never sets ext_flag and never raises irq.
- R4: On a wrap the counter takes the reload value held before that cycle. A reload write changes nothing until the next wrap. With reload 0xFF00 running, writing 0xFFFF right after a tick makes the next tick come 542 cycles later and the one after that 32 cycles later.
- R5: rx_sel=1 feeds the receive divider from the counter overflow. rx_sel=0 feeds it from alt_ovf_tick. Every 16 source pulses give one rx_tick.
- R6: tx_sel chooses the transmit source in the same way, independently of rx_sel.
- R7: With src_ext=1, the counter advances once per synchronized falling edge of ext_clk_pin and never from the system clock alone. The tick period is 16 × (65536 − reload) pin periods.
- R8: While run_en=0 the counter holds its value and produces no overflow, so counter-fed channels emit no ticks. Raising run_en again resumes the normal period.
- R9: With trig_en=1, a falling edge on trig_pin sets ext_flag. The flag becomes visible on the third clock edge after the pin is first sampled low. A rising edge, or any edge while trig_en=0, leaves the flag unchanged.
- R10: ext_flag stays set until a flag_clr pulse clears it. When a set and a clear land in the same cycle, the set wins.
- R11: irq is 1 exactly when ext_flag=1 and irq_en=1.
- R12: rx_tick and tx_tick are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_clk_pin | input | 1 | External count clock, asynchronous |
| trig_pin | input | 1 | External trigger, asynchronous |
| alt_ovf_tick | input | 1 | One-cycle overflow pulse from another timer |
| run_en | input | 1 | Counter run control |
| src_ext | input | 1 | 0: system clock / 2, 1: ext_clk_pin falling edges |
| rx_sel | input | 1 | Receive source: 1 counter overflow, 0 alt_ovf_tick |
| tx_sel | input | 1 | Transmit source: 1 counter overflow, 0 alt_ovf_tick |
| trig_en | input | 1 | Lets trig_pin falling edges set ext_flag |
| irq_en | input | 1 | Interrupt enable for ext_flag |
| reload_we | input | 1 | Write strobe for the reload register |
| reload_wdata | input | CNT_W | Reload value |
| flag_clr | input | 1 | Clears ext_flag |
| rx_tick | output | 1 | Receive baud tick, 16x bit rate |
| tx_tick | output | 1 | Transmit baud tick, 16x bit rate |
| ext_flag | output | 1 | Sticky trigger-edge flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps reload values from 0xFFFF, where every advance wraps, down to 0xFF80. At each value it compares the tick period with the arithmetic formula. A counter that reloaded one step off, or that advanced every cycle, would show periods off by 32 or by half. The reload-timing case writes a new value just after a tick and checks that the following interval still spans the old reload once. A design that loaded the counter on the write would tick after about 32 cycles instead of 542. The bench also checks all three combinations of the two source selects, external-pin counting with the pin idle and with it toggling, halting, exact trigger-flag latency, rising-edge rejection, and the set-over-clear collision. A design with swapped selects, a missed synchronizer stage, or clear priority would each break one of these.

// File: rtl/baud_timer_pkg.sv
package baud_timer_pkg;

   localparam int unsigned NUM_CH = 2;
   localparam int unsigned CH_RX  = 0;
   localparam int unsigned CH_TX  = 1;

   typedef enum logic {
      TB_SYSCLK = 1'b0,
      TB_PIN    = 1'b1
   } tbase_e;

endpackage

// File: rtl/btg_sync_edge.sv
module btg_sync_edge #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign fall = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/btg_timebase.sv
module btg_timebase
   import baud_timer_pkg::*;
#(
   parameter int unsigned PRESCALE_LOG2 = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   input  logic src_ext,
   input  logic pin_fall,
   output logic inc
);

   logic   int_step;
   tbase_e tbase;

   assign tbase = tbase_e'(src_ext);

   generate
      if (PRESCALE_LOG2 == 0) begin : g_no_pre
         assign int_step = 1'b1;
      end else begin : g_pre
         logic [PRESCALE_LOG2-1:0] pre_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pre_q <= '0;
            end else if (run_en) begin
               pre_q <= pre_q + 1'b1;
            end
         end
         assign int_step = &pre_q;
      end
   endgenerate

   always_comb begin
      unique case (tbase)
         TB_PIN:  inc = run_en & pin_fall;
         default: inc = run_en & int_step;
      endcase
   end

endmodule

// File: rtl/btg_reload_counter.sv
module btg_reload_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             rl_we,
   input  logic [CNT_W-1:0] rl_wdata,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] rl_val,
   output logic             ovf
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] rl_q;
   logic             ovf_q;
   logic             at_max;

   assign at_max = (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rl_q <= '0;
      end else if (rl_we) begin
         rl_q <= rl_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= CNT_MAX;
         ovf_q <= 1'b0;
      end else begin
         ovf_q <= inc & at_max;
         if (inc) begin
            cnt_q <= at_max ? rl_q : cnt_q + 1'b1;
         end
      end
   end

   assign cnt    = cnt_q;
   assign rl_val = rl_q;
   assign ovf    = ovf_q;

endmodule

// File: rtl/btg_tick_div.sv
module btg_tick_div #(
   parameter int unsigned DIV_LOG2 = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic src_tick,
   output logic tick
);

   logic [DIV_LOG2-1:0] ph_q;
   logic                tick_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q   <= '0;
         tick_q <= 1'b0;
      end else begin
         tick_q <= src_tick & (&ph_q);
         if (src_tick) begin
            ph_q <= ph_q + 1'b1;
         end
      end
   end

   assign tick = tick_q;

endmodule

// File: rtl/baud_timer_gen.sv
module baud_timer_gen
   import baud_timer_pkg::*;
#(
   parameter int unsigned CNT_W         = 16,
   parameter int unsigned TICK_DIV_LOG2 = 4,
   parameter int unsigned SYNC_STAGES   = 2,
   parameter int unsigned PRESCALE_LOG2 = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_clk_pin,
   input  logic             trig_pin,
   input  logic             alt_ovf_tick,
   input  logic             run_en,
   input  logic             src_ext,
   input  logic             rx_sel,
   input  logic             tx_sel,
   input  logic             trig_en,
   input  logic             irq_en,
   input  logic             reload_we,
   input  logic [CNT_W-1:0] reload_wdata,
   input  logic             flag_clr,
   output logic             rx_tick,
   output logic             tx_tick,
   output logic             ext_flag,
   output logic             irq
);

   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("CNT_W must be at least 2");
   end
   if (TICK_DIV_LOG2 < 1) begin : g_bad_div
      $error("TICK_DIV_LOG2 must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             pin_fall;
   logic             trig_fall;
   logic             cnt_inc;
   logic             ovf_tick;
   logic [CNT_W-1:0] cnt_val;
   logic [CNT_W-1:0] reload_val;
   logic             flag_q;
   logic [NUM_CH-1:0] ch_sel;
   logic [NUM_CH-1:0] ch_tick;

   btg_sync_edge #(.STAGES(SYNC_STAGES)) u_clk_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_clk_pin),
      .fall  (pin_fall)
   );

   btg_sync_edge #(.STAGES(SYNC_STAGES)) u_trig_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (trig_pin),
      .fall  (trig_fall)
   );

   btg_timebase #(.PRESCALE_LOG2(PRESCALE_LOG2)) u_tbase (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_en   (run_en),
      .src_ext  (src_ext),
      .pin_fall (pin_fall),
      .inc      (cnt_inc)
   );

   btg_reload_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (cnt_inc),
      .rl_we    (reload_we),
      .rl_wdata (reload_wdata),
      .cnt      (cnt_val),
      .rl_val   (reload_val),
      .ovf      (ovf_tick)
   );

   assign ch_sel[CH_RX] = rx_sel;
   assign ch_sel[CH_TX] = tx_sel;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic src;
      assign src = ch_sel[c] ? ovf_tick : alt_ovf_tick;
      btg_tick_div #(.DIV_LOG2(TICK_DIV_LOG2)) u_div (
         .clk      (clk),
         .rst_n    (rst_n),
         .src_tick (src),
         .tick     (ch_tick[c])
      );
   end

   assign rx_tick = ch_tick[CH_RX];
   assign tx_tick = ch_tick[CH_TX];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
      end else if (trig_fall && trig_en) begin
         flag_q <= 1'b1;
      end else if (flag_clr) begin
         flag_q <= 1'b0;
      end
   end

   assign ext_flag = flag_q;
   assign irq      = flag_q & irq_en;

endmodule

// File: rtl/baud_timer_gen_chk.sv
module baud_timer_gen_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             run_en,
   input logic             src_ext,
   input logic             rx_sel,
   input logic             tx_sel,
   input logic             trig_en,
   input logic             irq_en,
   input logic             flag_clr,
   input logic             alt_ovf_tick,
   input logic             rx_tick,
   input logic             tx_tick,
   input logic             ext_flag,
   input logic             irq,
   input logic [CNT_W-1:0] cnt_val,
   input logic [CNT_W-1:0] reload_val,
   input logic             ovf_tick,
   input logic             cnt_inc,
   input logic             trig_fall
);

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc && (cnt_val != {CNT_W{1'b1}})) |=> (cnt_val == CNT_W'($past(cnt_val) + 1'b1)));

   p_half_rate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_inc && !src_ext) |=> (src_ext || !cnt_inc));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_flag) |-> $past(trig_fall && trig_en));

   p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_tick |-> (cnt_val == $past(reload_val)));

   p_rx_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |-> $past(rx_sel ? ovf_tick : alt_ovf_tick));

   p_tx_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |-> $past(tx_sel ? ovf_tick : alt_ovf_tick));

   p_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> ($stable(cnt_val) && !ovf_tick));

   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_flag && !flag_clr) |=> ext_flag);

   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !(trig_fall && trig_en)) |=> !ext_flag);

   p_irq_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ext_flag);

   p_irq_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> !irq);

   p_rx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rx_tick |=> !rx_tick);

   p_tx_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
      tx_tick |=> !tx_tick);

endmodule

bind baud_timer_gen baud_timer_gen_chk #(.CNT_W(CNT_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .run_en       (run_en),
   .src_ext      (src_ext),
   .rx_sel       (rx_sel),
   .tx_sel       (tx_sel),
   .trig_en      (trig_en),
   .irq_en       (irq_en),
   .flag_clr     (flag_clr),
   .alt_ovf_tick (alt_ovf_tick),
   .rx_tick      (rx_tick),
   .tx_tick      (tx_tick),
   .ext_flag     (ext_flag),
   .irq          (irq),
   .cnt_val      (cnt_val),
   .reload_val   (reload_val),
   .ovf_tick     (ovf_tick),
   .cnt_inc      (cnt_inc),
   .trig_fall    (trig_fall)
);

// File: tb/baud_timer_gen_tb_top.sv
module baud_timer_gen_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_clk_pin = 1'b1;
   logic        trig_pin = 1'b1;
   logic        alt_ovf_tick = 1'b0;
   logic        run_en = 1'b0;
   logic        src_ext = 1'b0;
   logic        rx_sel = 1'b0;
   logic        tx_sel = 1'b0;
   logic        trig_en = 1'b0;
   logic        irq_en = 1'b0;
   logic        reload_we = 1'b0;
   logic [15:0] reload_wdata = '0;
   logic        flag_clr = 1'b0;
   logic        rx_tick;
   logic        tx_tick;
   logic        ext_flag;
   logic        irq;

   int     checks = 0;
   int     errors = 0;
   longint cyc = 0;
   bit     alt_on = 0;
   bit     ext_on = 0;
   int     alt_ph = 0;
   int     ext_ph = 0;
   int     dbl = 0;
   logic   rx_prev = 1'b0;
   logic   tx_prev = 1'b0;

   baud_timer_gen dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .ext_clk_pin  (ext_clk_pin),
      .trig_pin     (trig_pin),
      .alt_ovf_tick (alt_ovf_tick),
      .run_en       (run_en),
      .src_ext      (src_ext),
      .rx_sel       (rx_sel),
      .tx_sel       (tx_sel),
      .trig_en      (trig_en),
      .irq_en       (irq_en),
      .reload_we    (reload_we),
      .reload_wdata (reload_wdata),
      .flag_clr     (flag_clr),
      .rx_tick      (rx_tick),
      .tx_tick      (tx_tick),
      .ext_flag     (ext_flag),
      .irq          (irq)
   );

   always #5 clk = ~clk;

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (alt_on) begin
         alt_ovf_tick <= (alt_ph == 9);
         alt_ph       <= (alt_ph == 9) ? 0 : alt_ph + 1;
      end else begin
         alt_ovf_tick <= 1'b0;
      end
   end

   always @(negedge clk) begin
      if (ext_on) begin
         ext_clk_pin <= (ext_ph < 3);
         ext_ph      <= (ext_ph == 5) ? 0 : ext_ph + 1;
      end else begin
         ext_clk_pin <= 1'b1;
      end
   end

   always @(negedge clk) begin
      if (rx_tick && rx_prev) dbl = dbl + 1;
      if (tx_tick && tx_prev) dbl = dbl + 1;
      rx_prev <= rx_tick;
      tx_prev <= tx_tick;
   end

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic write_reload(input logic [15:0] v);
      reload_wdata = v;
      reload_we    = 1'b1;
      @(negedge clk);
      reload_we    = 1'b0;
   endtask

   task automatic wait_tick(input int ch, input int limit, output longint t);
      bit found = 0;
      t = -1;
      for (int i = 0; i < limit && !found; i++) begin
         @(negedge clk);
         if ((ch == 0 && rx_tick) || (ch == 1 && tx_tick)) begin
            found = 1;
            t = cyc;
         end
      end
   endtask

   task automatic measure(input int ch, output longint per);
      longint t0, t1;
      wait_tick(ch, 20000, t0);
      wait_tick(ch, 20000, t0);
      wait_tick(ch, 20000, t0);
      wait_tick(ch, 20000, t1);
      per = (t0 < 0 || t1 < 0) ? -1 : t1 - t0;
   endtask

   task automatic count_ticks(input int n, output int rxc, output int txc);
      rxc = 0;
      txc = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (rx_tick) rxc++;
         if (tx_tick) txc++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      longint t0, t1, per;
      int     rc, tc;
      logic [15:0] sweep [5] = '{16'hFFFF, 16'hFFFE, 16'hFFFC, 16'hFFF0, 16'hFF80};

      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!rx_tick && !tx_tick, "R1 ticks idle after reset", rx_tick + tx_tick, 0);
      chk(!ext_flag && !irq, "R1 flag and irq idle after reset", ext_flag + irq, 0);

      trig_en = 1'b1;
      irq_en  = 1'b1;
      rx_sel  = 1'b1;
      tx_sel  = 1'b1;
      write_reload(16'hFFFF);
      run_en = 1'b1;
      t0 = cyc;
      wait_tick(0, 1000, t1);
      // R1: counter starts at all ones, first advance reloads
      chk(t1 - t0 == 33, "R1 first tick latency", t1 - t0, 33);

      // R2: internal timebase period sweep
      foreach (sweep[i]) begin
         write_reload(sweep[i]);
         measure(0, per);
         chk(per == 32 * (65536 - longint'(sweep[i])), "R2 internal period",
             per, 32 * (65536 - longint'(sweep[i])));
         chk(tx_tick == 1'b1, "R6 tx tick with rx when both select counter", tx_tick, 1);
      end
      // R3: many wraps, flag untouched
      chk(!ext_flag && !irq, "R3 overflow leaves flag and irq clear", ext_flag + irq, 0);

      // R4: reload write takes effect at next wrap
      write_reload(16'hFF00);
      wait_tick(0, 20000, t0);
      wait_tick(0, 20000, t0);
      wait_tick(0, 20000, t0);
      write_reload(16'hFFFF);
      wait_tick(0, 20000, t1);
      chk(t1 - t0 == 542, "R4 interval after reload write", t1 - t0, 542);
      wait_tick(0, 1000, t0);
      chk(t0 - t1 == 32, "R4 interval with new reload", t0 - t1, 32);

      // R5/R6: independent source selects
      alt_on = 1;
      for (int s = 0; s < 3; s++) begin
         rx_sel = (s == 0);
         tx_sel = (s == 1);
         measure(0, per);
         chk(per == (rx_sel ? 32 : 160), "R5 rx source period", per, rx_sel ? 32 : 160);
         measure(1, per);
         chk(per == (tx_sel ? 32 : 160), "R6 tx source period", per, tx_sel ? 32 : 160);
      end

      // R8: halt
      alt_on = 0;
      rx_sel = 1'b1;
      tx_sel = 1'b1;
      run_en = 1'b0;
      count_ticks(700, rc, tc);
      chk(rc == 0 && tc == 0, "R8 no ticks while halted", rc + tc, 0);
      run_en = 1'b1;
      measure(0, per);
      chk(per == 32, "R8 period after resume", per, 32);

      // R7: external timebase
      src_ext = 1'b1;
      count_ticks(700, rc, tc);
      chk(rc == 0, "R7 no count from system clock in pin mode", rc, 0);
      ext_on = 1;
      write_reload(16'hFFFC);
      measure(0, per);
      chk(per == 384, "R7 pin period reload FFFC", per, 384);
      write_reload(16'hFFFF);
      measure(0, per);
      chk(per == 96, "R7 pin period reload FFFF", per, 96);
      run_en = 1'b0;
      count_ticks(800, rc, tc);
      chk(rc == 0 && tc == 0, "R8 no ticks halted in pin mode", rc + tc, 0);
      chk(!ext_flag, "R3 flag clear after pin-mode wraps", ext_flag, 0);

      // R9: trigger edge handling
      trig_en = 1'b0;
      irq_en  = 1'b0;
      trig_pin = 1'b0;
      repeat (5) @(negedge clk);
      chk(!ext_flag, "R9 edge ignored while disabled", ext_flag, 0);
      trig_pin = 1'b1;
      repeat (5) @(negedge clk);
      trig_en = 1'b1;
      trig_pin = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(!ext_flag, "R9 flag not early", ext_flag, 0);
      @(negedge clk);
      chk(ext_flag, "R9 flag on third edge", ext_flag, 1);
      chk(!irq, "R11 irq masked", irq, 0);
      irq_en = 1'b1;
      @(negedge clk);
      chk(irq, "R11 irq with flag and enable", irq, 1);

      // R10: hold and clear
      repeat (20) @(negedge clk);
      chk(ext_flag, "R10 flag held", ext_flag, 1);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(!ext_flag && !irq, "R10 flag cleared", ext_flag + irq, 0);
      trig_pin = 1'b1;
      repeat (6) @(negedge clk);
      chk(!ext_flag, "R9 rising edge ignored", ext_flag, 0);
      trig_pin = 1'b0;
      @(negedge clk);
      @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      chk(ext_flag, "R10 set wins over clear", ext_flag, 1);

      // R12: single-cycle ticks throughout
      chk(dbl == 0, "R12 ticks never two cycles long", dbl, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule